// File: doc/BRIEF.md
# Trimmed-Rate Precision Time Counter

This block keeps a network time-of-day value as a seconds count and a nanoseconds count. A fixed reference clock drives it. Software sets the rate at which the nanoseconds count advances in two ways. A nanosecond step size sets the rate coarsely. A 32-bit phase addend sets it finely: in fine mode the step is applied only on the clock edges where a 32-bit phase accumulator wraps. Software can therefore raise the coarse step above nominal and then use the addend to slow the counter back down to the exact rate it needs.

The nanoseconds count rolls over in decimal. Whenever a step would reach one billion, the excess nanoseconds are kept, the seconds count goes up by one, and a one-clock pulse marks the second boundary. Software programs the block through a three-register write port: phase addend, step size and mode. A separate load strobe sets the time directly.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset (`rst_n` low, synchronous to `clk`), `sec_o`, `ns_o` and `pps_o` are zero, and the addend, step size and mode register are zero. With no register written, the time stays at zero.
- R2: In coarse mode (mode register bit 0 = 0), `ns_o` advances by the step size on every clock edge.
- R3: In fine mode (mode bit 0 = 1), each edge adds the addend to the 32-bit phase accumulator. `ns_o` advances by the step size only on edges where that addition carries out of bit 31. On all other edges `sec_o` and `ns_o` hold. With addend 0x80000000 and step 40 starting from phase 0, the time advances on every second edge, averaging 20 ns per clock.
- R4: With addend 0xFFFFFFFF starting from phase 0, the first edge gives no step. Every later edge steps.
- R5: When `ns_o` plus the step reaches or passes 1,000,000,000, `ns_o` becomes that sum minus 1,000,000,000 and `sec_o` increments. `ns_o` never reaches 1,000,000,000.
- R6: `pps_o` is high for exactly one clock, in the same cycle in which `sec_o` shows the incremented value. It is low in every other cycle, including after a time load.
- R7: Write port: `reg_sel` = 0 selects the addend (32 bits), 1 selects the step size (low 8 bits of `reg_wdata`), and 2 selects the mode (bit 0). A write captured on an edge is used from the following edge. The edge that captures the write still uses the old value, and the write changes neither the phase accumulator nor the time.
- R8: When `time_load` is high on an edge, `sec_o` takes `load_sec` and `ns_o` takes `load_ns`. A `load_ns` of 1,000,000,000 or more is stored as 999,999,999. The load takes priority over stepping on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 addend, 1 step size, 2 mode |
| reg_wdata | input | 32 | Register write data |
| time_load | input | 1 | Direct time load strobe |
| load_sec | input | SEC_W | Seconds value to load |
| load_ns | input | NS_W | Nanoseconds value to load |
| sec_o | output | SEC_W | Seconds count |
| ns_o | output | NS_W | Nanoseconds count |
| pps_o | output | 1 | One-clock pulse at each seconds increment |

## Verification
The bench goes after the edge where the phase accumulator wraps. A design that steps on every edge in fine mode, or drops the first-edge gap at the largest addend, gives the wrong nanosecond totals after a known count of edges. Rollovers that land exactly on one billion, and rollovers that overshoot it, are both exercised. A design that clears the remainder, or compares with the wrong bound, shows up as a wrong `ns_o` or a missing seconds carry and pulse. Registers are rewritten in mid-run to catch two faults: a write that takes effect one edge early, and a write that resets the phase accumulator and so shifts the later step edges. Loads above the legal range catch a missing clamp.

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30,
  parameter int INC_W = 8,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  input  logic             time_load,
  input  logic [SEC_W-1:0] load_sec,
  input  logic [NS_W-1:0]  load_ns,
  output logic [SEC_W-1:0] sec_o,
  output logic [NS_W-1:0]  ns_o,
  output logic             pps_o
);

  localparam logic [NS_W:0]   BILLION = (NS_W+1)'(1000000000);
  localparam logic [NS_W-1:0] NS_TOP  = NS_W'(999999999);
  localparam logic [1:0] SEL_ADDEND = 2'd0;
  localparam logic [1:0] SEL_STEP   = 2'd1;
  localparam logic [1:0] SEL_MODE   = 2'd2;

  logic [ACC_W-1:0] addend_q, phase_q;
  logic [INC_W-1:0] step_q;
  logic             fine_q;

  logic [ACC_W:0]  phase_sum;
  logic            advance;
  logic [NS_W:0]   ns_sum;
  logic            wrap;
  logic [NS_W-1:0] ns_loaded;

  assign phase_sum = {1'b0, phase_q} + {1'b0, addend_q};
  assign advance   = fine_q ? phase_sum[ACC_W] : 1'b1;
  assign ns_sum    = {1'b0, ns_o} + (NS_W+1)'(step_q);
  assign wrap      = advance && (ns_sum >= BILLION);
  assign ns_loaded = ({1'b0, load_ns} >= BILLION) ? NS_TOP : load_ns;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addend_q <= '0;
      step_q   <= '0;
      fine_q   <= 1'b0;
    end else if (reg_we) begin
      case (reg_sel)
        SEL_ADDEND: addend_q <= reg_wdata[ACC_W-1:0];
        SEL_STEP:   step_q   <= reg_wdata[INC_W-1:0];
        SEL_MODE:   fine_q   <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      phase_q <= '0;
    else if (fine_q)
      phase_q <= phase_sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_o <= '0;
      ns_o  <= '0;
      pps_o <= 1'b0;
    end else if (time_load) begin
      sec_o <= load_sec;
      ns_o  <= ns_loaded;
      pps_o <= 1'b0;
    end else if (wrap) begin
      sec_o <= sec_o + 1'b1;
      ns_o  <= NS_W'(ns_sum - BILLION);
      pps_o <= 1'b1;
    end else begin
      if (advance) ns_o <= ns_sum[NS_W-1:0];
      pps_o <= 1'b0;
    end
  end

  p_ns_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ns_o} < BILLION);

  p_pps_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pps_o |-> (sec_o == $past(sec_o) + 1'b1));

  p_pps_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pps_o |=> !pps_o);

  p_fine_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fine_q && !time_load && !phase_sum[ACC_W]) |=> ($stable(ns_o) && $stable(sec_o)));

  p_load_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (time_load && ({1'b0, load_ns} >= BILLION)) |=> (ns_o == NS_TOP));

  p_load_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    time_load |=> (sec_o == $past(load_sec) && !pps_o));

endmodule

// File: tb/ptp_time_counter_test.sv
module ptp_time_counter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        time_load;
  logic [31:0] load_sec;
  logic [29:0] load_ns;
  logic [31:0] sec_o;
  logic [29:0] ns_o;
  logic        pps_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ptp_time_counter uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .time_load(time_load), .load_sec(load_sec),
    .load_ns(load_ns), .sec_o(sec_o), .ns_o(ns_o), .pps_o(pps_o)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic load(logic [31:0] s, logic [29:0] n);
    time_load = 1'b1; load_sec = s; load_ns = n;
    @(negedge clk);
    time_load = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "sec after reset", sec_o, 0);
    check("R1", "ns after reset", ns_o, 0);
    check("R1", "pps after reset", pps_o, 0);
    idle(8);
    check("R1", "ns idle with zero step", ns_o, 0);
    check("R1", "sec idle with zero step", sec_o, 0);
  endtask

  task automatic t_coarse();
    do_reset();
    wr(2'd1, 32'd21);
    check("R7", "step write uses old step on capture edge", ns_o, 0);
    idle(10);
    check("R2", "coarse 10 edges of 21", ns_o, 210);
    wr(2'd1, 32'd20);
    check("R7", "capture edge still steps 21", ns_o, 231);
    idle(2);
    check("R2", "coarse after step change", ns_o, 271);
  endtask

  task automatic t_fine_half();
    do_reset();
    wr(2'd2, 32'd1);
    wr(2'd0, 32'h8000_0000);
    wr(2'd1, 32'd40);
    check("R3", "no step before first wrap", ns_o, 0);
    idle(1);
    check("R3", "first wrap step", ns_o, 40);
    idle(1);
    check("R3", "hold on non-wrap edge", ns_o, 40);
    idle(8);
    check("R3", "ten edges at half addend", ns_o, 200);
    // R7: rewrite addend mid-run, phase must survive
    wr(2'd0, 32'h4000_0000);
    check("R7", "capture edge uses old addend", ns_o, 240);
    idle(3);
    check("R7", "quarter addend no wrap yet", ns_o, 240);
    idle(1);
    check("R7", "quarter addend wraps on fourth edge", ns_o, 280);
  endtask

  task automatic t_fine_full();
    do_reset();
    wr(2'd2, 32'd1);
    wr(2'd1, 32'd20);
    wr(2'd0, 32'hFFFF_FFFF);
    idle(1);
    check("R4", "first edge at full addend no step", ns_o, 0);
    idle(5);
    check("R4", "every later edge steps", ns_o, 100);
  endtask

  task automatic t_rollover();
    do_reset();
    wr(2'd1, 32'd20);
    load(32'd5, 30'd999_999_960);
    check("R8", "loaded ns", ns_o, 999_999_960);
    check("R8", "loaded sec", sec_o, 5);
    check("R6", "no pulse on load", pps_o, 0);
    idle(1);
    check("R2", "step before boundary", ns_o, 999_999_980);
    check("R6", "no pulse before boundary", pps_o, 0);
    idle(1);
    check("R5", "exact billion wraps to zero", ns_o, 0);
    check("R5", "sec carries", sec_o, 6);
    check("R6", "pulse at boundary", pps_o, 1);
    idle(1);
    check("R6", "pulse lasts one clock", pps_o, 0);
    check("R2", "step after boundary", ns_o, 20);
    load(32'd9, 30'd999_999_990);
    idle(1);
    check("R5", "overshoot keeps remainder", ns_o, 10);
    check("R5", "sec carries on overshoot", sec_o, 10);
  endtask

  task automatic t_clamp();
    do_reset();
    wr(2'd1, 32'd20);
    load(32'h1234_5678, 30'd1_050_000_000);
    check("R8", "clamped ns", ns_o, 999_999_999);
    check("R8", "loaded sec", sec_o, 32'h1234_5678);
    idle(1);
    check("R5", "wrap from clamped value", ns_o, 19);
    check("R5", "sec after clamp wrap", sec_o, 32'h1234_5679);
    load(32'd0, 30'd1_000_000_000);
    check("R8", "exact billion load clamps", ns_o, 999_999_999);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    time_load = 1'b0; load_sec = '0; load_ns = '0;
    @(negedge clk);
    t_reset();
    t_coarse();
    t_fine_half();
    t_fine_full();
    t_rollover();
    t_clamp();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule